// File: doc/BRIEF.md
# Tuning-Loop Reference Divider, Phase Detector and Lock Flag

This block sits in the frequency-synthesis loop of a tuner. It takes the crystal clock as its only clock and divides it by a ratio picked from a small mode table. The result is a one-cycle comparison strobe. That strobe and the divided oscillator feedback go into a two-flop phase-frequency detector. The detector drives the up and down controls of an external charge pump. The ratio sets the comparison rate, and with it the tuning step. With a 4 MHz crystal and the prescaler of 8, the three ratios give steps of 31.25 kHz, 50 kHz and 62.5 kHz.

Every comparison measures the phase error in crystal cycles. A run of in-window comparisons raises a lock flag, which is used both as a pin and as a status bit. The first comparison whose error is outside the window drops the flag at once. A change of the effective ratio clears the flag and restarts the reference counter. So does a pulse that marks a rewrite of the main divider. The pump can be muted, and the pump-current select bit is passed through to the analog side.

Top module: `ref_pfd_lock`

## Requirements
- R1: The ratio depends on `mode_sel`: mode 0 divides by 1024, modes 1 and 3 divide by 512, and mode 2 divides by 640. `ref_tick_o` is high for one cycle in every ratio-length period.
- R2: In mode 4 the ratio comes from `ref_sel` (bit 1 is the high bit). If `ref_sel[0]`=0 the ratio is 640. `ref_sel`=01 gives 1024 and `ref_sel`=11 gives 512.
- R3: Modes 5, 6 and 7 divide by 1024.
- R4: While `pump_off`=1, `pump_up` and `pump_dn` are both 0.
- R5: `pump_hi_sel` equals `pump_hi` (1 selects the high pump current, 0 the low one).
- R6: `pump_up` rises in the cycle after a `ref_tick_o` strobe. `pump_dn` rises in the cycle after a rising edge of `fb_in` is sampled. When both are high for one cycle (a comparison), both fall in the next cycle. The phase error of that comparison is the number of cycles in which only one of the two was high.
- R7: `lock_o` goes to 1 in the cycle after the 8th consecutive comparison whose error is at most 4 cycles. It goes to 0 in the cycle after the first comparison whose error is above 4 cycles.
- R8: A change of `mode_sel`/`ref_sel` that changes the effective ratio clears `lock_o` on the next cycle and restarts the counter. The next strobe then comes exactly one new ratio of cycles after the change. A change that keeps the same ratio leaves the lock and the counter phase untouched.
- R9: A one-cycle `div_load` pulse clears `lock_o` and restarts the reference counter in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_in | input | 1 | Divided oscillator feedback, synchronous to clk |
| mode_sel | input | 3 | Step-mode code |
| ref_sel | input | 2 | Ratio select used in mode 4 |
| pump_hi | input | 1 | Pump current select (1 = high) |
| pump_off | input | 1 | Mutes both pump controls |
| div_load | input | 1 | Pulse when the main divider ratio is rewritten |
| ref_tick_o | output | 1 | Comparison-rate strobe |
| pump_up | output | 1 | Charge-pump source control |
| pump_dn | output | 1 | Charge-pump sink control |
| pump_hi_sel | output | 1 | Current select to the analog pump |
| lock_o | output | 1 | Lock flag for the pin and the status byte |

## Verification
The bench builds the block with its default parameters: ratios of 512, 640 and 1024, a lock run of 8 and an error window of 4 cycles, with rising-edge feedback. The window is small, so a feedback lag of 4 cycles and one of 5 cycles test both sides of the lock boundary. The 512 and 640 ratios keep each comparison short enough for several complete lock, loss and relock runs, and a restart-timing check for both ratio-change paths.

// File: rtl/ref_pfd_pkg.sv
package ref_pfd_pkg;

   // Effective reference ratio class; the divider maps it to a terminal count.
   typedef enum logic [1:0] {
      STEP_FINE   = 2'd0,
      STEP_MID    = 2'd1,
      STEP_COARSE = 2'd2
   } step_e;

   function automatic step_e step_of(input logic [2:0] mode, input logic [1:0] rsel);
      step_e s;
      case (mode)
         3'd1, 3'd3: s = STEP_COARSE;
         3'd2:       s = STEP_MID;
         3'd4: begin
            if (!rsel[0])     s = STEP_MID;
            else if (rsel[1]) s = STEP_COARSE;
            else              s = STEP_FINE;
         end
         default:    s = STEP_FINE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ref_step_sel.sv
module ref_step_sel
   import ref_pfd_pkg::*;
(
   input  logic [2:0] mode_i,
   input  logic [1:0] rsel_i,
   output step_e      step_o
);

   assign step_o = step_of(mode_i, rsel_i);

endmodule

// File: rtl/ref_divider.sv
module ref_divider
   import ref_pfd_pkg::*;
#(
   parameter int DIV_FINE   = 1024,
   parameter int DIV_MID    = 640,
   parameter int DIV_COARSE = 512
)(
   input  logic  clk,
   input  logic  rst_n,
   input  step_e step_i,
   input  logic  load_i,
   output logic  ratio_chg_o,
   output logic  tick_o
);

   localparam int CNT_W = $clog2(DIV_FINE);
   localparam logic [CNT_W-1:0] TC_FINE   = CNT_W'(DIV_FINE - 1);
   localparam logic [CNT_W-1:0] TC_MID    = CNT_W'(DIV_MID - 1);
   localparam logic [CNT_W-1:0] TC_COARSE = CNT_W'(DIV_COARSE - 1);

   step_e            step_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tc;

   always_comb begin
      case (step_q)
         STEP_MID:    tc = TC_MID;
         STEP_COARSE: tc = TC_COARSE;
         default:     tc = TC_FINE;
      endcase
   end

   assign ratio_chg_o = (step_i != step_q);
   assign tick_o      = (cnt_q == tc) && !ratio_chg_o && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= STEP_FINE;
         cnt_q  <= '0;
      end else if (ratio_chg_o || load_i) begin
         step_q <= step_i;
         cnt_q  <= '0;
      end else if (cnt_q == tc) begin
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter bit FB_RISING = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick_i,
   input  logic fb_i,
   input  logic clear_i,
   output logic up_o,
   output logic dn_o
);

   logic fb_q;
   logic fb_edge;

   generate
      if (FB_RISING) begin : g_rise
         assign fb_edge = fb_i & ~fb_q;
      end else begin : g_fall
         assign fb_edge = ~fb_i & fb_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_q <= 1'b0;
         up_o <= 1'b0;
         dn_o <= 1'b0;
      end else begin
         fb_q <= fb_i;
         if (clear_i) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
         end else if (up_o && dn_o) begin
            // common reset; an edge arriving in this cycle starts the next race
            up_o <= ref_tick_i;
            dn_o <= fb_edge;
         end else begin
            up_o <= up_o | ref_tick_i;
            dn_o <= dn_o | fb_edge;
         end
      end
   end

endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
   parameter int LOCK_CYCLES = 8,
   parameter int ERR_WIN     = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic up_i,
   input  logic dn_i,
   input  logic clear_i,
   output logic locked_o
);

   localparam int ERR_W  = $clog2(ERR_WIN + 2);
   localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
   localparam logic [ERR_W-1:0]  WIN_V    = ERR_W'(ERR_WIN);
   localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_CYCLES);

   logic [ERR_W-1:0]  err_q;
   logic [GOOD_W-1:0] good_q;
   logic              cmp;
   logic              in_win;

   assign cmp    = up_i & dn_i;
   assign in_win = (err_q <= WIN_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q    <= '0;
         good_q   <= '0;
         locked_o <= 1'b0;
      end else if (clear_i) begin
         err_q    <= '0;
         good_q   <= '0;
         locked_o <= 1'b0;
      end else if (cmp) begin
         err_q <= '0;
         if (in_win) begin
            if (good_q != GOOD_MAX) good_q <= good_q + 1'b1;
            if (good_q >= GOOD_MAX - 1'b1) locked_o <= 1'b1;
         end else begin
            good_q   <= '0;
            locked_o <= 1'b0;
         end
      end else if ((up_i ^ dn_i) && (err_q != '1)) begin
         err_q <= err_q + 1'b1;
      end
   end

endmodule

// File: rtl/ref_pfd_lock.sv
module ref_pfd_lock
   import ref_pfd_pkg::*;
#(
   parameter int DIV_FINE    = 1024,
   parameter int DIV_MID     = 640,
   parameter int DIV_COARSE  = 512,
   parameter int LOCK_CYCLES = 8,
   parameter int ERR_WIN     = 4,
   parameter bit FB_RISING   = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fb_in,
   input  logic [2:0] mode_sel,
   input  logic [1:0] ref_sel,
   input  logic       pump_hi,
   input  logic       pump_off,
   input  logic       div_load,
   output logic       ref_tick_o,
   output logic       pump_up,
   output logic       pump_dn,
   output logic       pump_hi_sel,
   output logic       lock_o
);

   generate
      if (DIV_COARSE < 2 || DIV_COARSE >= DIV_MID || DIV_MID >= DIV_FINE) begin : g_bad_ratio
         $error("ref_pfd_lock: ratios must satisfy 2 <= COARSE < MID < FINE");
      end
      if (LOCK_CYCLES < 1 || ERR_WIN < 0) begin : g_bad_lock
         $error("ref_pfd_lock: LOCK_CYCLES must be >= 1 and ERR_WIN >= 0");
      end
   endgenerate

   step_e step;
   logic  ratio_chg;
   logic  restart;
   logic  up_q;
   logic  dn_q;

   ref_step_sel u_sel (
      .mode_i (mode_sel),
      .rsel_i (ref_sel),
      .step_o (step)
   );

   ref_divider #(
      .DIV_FINE   (DIV_FINE),
      .DIV_MID    (DIV_MID),
      .DIV_COARSE (DIV_COARSE)
   ) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step),
      .load_i      (div_load),
      .ratio_chg_o (ratio_chg),
      .tick_o      (ref_tick_o)
   );

   assign restart = ratio_chg | div_load;

   pfd_core #(
      .FB_RISING (FB_RISING)
   ) u_pfd (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick_i (ref_tick_o),
      .fb_i       (fb_in),
      .clear_i    (restart),
      .up_o       (up_q),
      .dn_o       (dn_q)
   );

   lock_detect #(
      .LOCK_CYCLES (LOCK_CYCLES),
      .ERR_WIN     (ERR_WIN)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_i     (up_q),
      .dn_i     (dn_q),
      .clear_i  (restart),
      .locked_o (lock_o)
   );

   assign pump_up     = up_q & ~pump_off;
   assign pump_dn     = dn_q & ~pump_off;
   assign pump_hi_sel = pump_hi;

endmodule

// File: rtl/ref_pfd_lock_chk.sv
module ref_pfd_lock_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_tick_o,
   input logic pump_off,
   input logic pump_up,
   input logic pump_dn,
   input logic div_load,
   input logic lock_o,
   input logic up_q,
   input logic dn_q,
   input logic ratio_chg
);

   // R1: the strobe never lasts two cycles
   p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ref_tick_o |=> !ref_tick_o);

   // R4: muted pump drives neither control
   p_pump_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pump_off |-> (!pump_up && !pump_dn));

   // R6: a strobe arms the up flop on the next cycle
   p_ref_arms_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_tick_o |=> up_q);

   // R7: lock only rises right after a comparison
   p_lock_after_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(up_q && dn_q));

   // R8: an effective ratio change drops lock and restarts the count
   p_ratio_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_chg |=> (!lock_o && !ref_tick_o));

   // R9: a divider rewrite drops lock
   p_load_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      div_load |=> !lock_o);

endmodule

bind ref_pfd_lock ref_pfd_lock_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_tick_o (ref_tick_o),
   .pump_off   (pump_off),
   .pump_up    (pump_up),
   .pump_dn    (pump_dn),
   .div_load   (div_load),
   .lock_o     (lock_o),
   .up_q       (up_q),
   .dn_q       (dn_q),
   .ratio_chg  (ratio_chg)
);

// File: tb/ref_pfd_lock_test.sv
module ref_pfd_lock_test;

   localparam int WIN   = 4;
   localparam int NLOCK = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fb_in = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic [1:0] ref_sel = 2'b01;
   logic       pump_hi = 1'b0;
   logic       pump_off = 1'b0;
   logic       div_load = 1'b0;
   logic       ref_tick_o, pump_up, pump_dn, pump_hi_sel, lock_o;

   ref_pfd_lock uut (
      .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .mode_sel(mode_sel),
      .ref_sel(ref_sel), .pump_hi(pump_hi), .pump_off(pump_off),
      .div_load(div_load), .ref_tick_o(ref_tick_o), .pump_up(pump_up),
      .pump_dn(pump_dn), .pump_hi_sel(pump_hi_sel), .lock_o(lock_o)
   );

   always #5 clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   bit    gen_en = 1'b0;
   int    lag_r  = 0;
   int    good_m = 0;
   bit    exp_q[$];
   string tag_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // feedback source: one pulse lag_r cycles after each strobe
   initial forever begin
      @(negedge clk);
      if (gen_en && ref_tick_o) begin
         repeat (lag_r) @(negedge clk);
         fb_in = 1'b1;
         @(negedge clk);
         fb_in = 1'b0;
      end
   end

   // monitor: every visible comparison consumes one expected lock value
   initial forever begin
      @(negedge clk);
      if (pump_up && pump_dn) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", 1, 0, "unexpected comparison");
         end else begin
            @(negedge clk);
            check(lock_o == exp_q[0], tag_q[0], int'(lock_o), int'(exp_q[0]), "lock after comparison");
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   task automatic expect_cmp(input int lag, input string tag);
      if (lag <= WIN) begin
         if (good_m < NLOCK) good_m++;
         exp_q.push_back(good_m >= NLOCK);
      end else begin
         good_m = 0;
         exp_q.push_back(1'b0);
      end
      tag_q.push_back(tag);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_cmp(input int lag, input int n, input string tag);
      lag_r = lag;
      for (int i = 0; i < n; i++) expect_cmp(lag, tag);
      drain();
   endtask

   task automatic measure(input int exp, input string tag);
      int n = 0;
      do @(negedge clk); while (!ref_tick_o);
      do begin @(negedge clk); n++; end while (!ref_tick_o);
      check(n == exp, tag, n, exp, "strobe period");
   endtask

   task automatic count_to_tick(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!ref_tick_o);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy expected finished");
      report();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(!lock_o, "R7", int'(lock_o), 0, "lock in reset");
      check(!pump_up && !pump_dn, "R6", int'({pump_up, pump_dn}), 0, "pumps in reset");
      check(!ref_tick_o, "R1", int'(ref_tick_o), 0, "strobe in reset");
      rst_n = 1'b1;

      pump_hi = 1'b1; #1;
      check(pump_hi_sel == 1'b1, "R5", int'(pump_hi_sel), 1, "current select high");
      pump_hi = 1'b0; #1;
      check(pump_hi_sel == 1'b0, "R5", int'(pump_hi_sel), 0, "current select low");

      mode_sel = 3'd0; measure(1024, "R1");
      mode_sel = 3'd1; measure(512,  "R1");
      mode_sel = 3'd2; measure(640,  "R1");
      mode_sel = 3'd3; measure(512,  "R1");
      mode_sel = 3'd4; ref_sel = 2'b01; measure(1024, "R2");
      ref_sel = 2'b11; measure(512, "R2");
      ref_sel = 2'b00; measure(640, "R2");
      ref_sel = 2'b10; measure(640, "R2");
      mode_sel = 3'd5; measure(1024, "R3");
      mode_sel = 3'd7; measure(1024, "R3");

      // R8 restart timing: switch mid-period from 1024 to 512
      do @(negedge clk); while (!ref_tick_o);
      repeat (100) @(negedge clk);
      mode_sel = 3'd1;
      count_to_tick(n);
      check(n == 512, "R8", n, 512, "cycles from ratio change to strobe");

      // clean start of the loop
      div_load = 1'b1; @(negedge clk); div_load = 1'b0;
      good_m = 0;
      gen_en = 1'b1;

      // R6 detector sequence with a 3-cycle lag
      lag_r = 3;
      expect_cmp(3, "R6");
      do @(negedge clk); while (!ref_tick_o);
      @(negedge clk);
      check(pump_up && !pump_dn, "R6", int'({pump_up, pump_dn}), 2, "up only after strobe");
      repeat (3) @(negedge clk);
      check(pump_up && pump_dn, "R6", int'({pump_up, pump_dn}), 3, "both at comparison");
      @(negedge clk);
      check(!pump_up && !pump_dn, "R6", int'({pump_up, pump_dn}), 0, "both released");
      drain();

      run_cmp(0, 9, "R7");
      run_cmp(4, 2, "R7");
      run_cmp(5, 1, "R7");
      run_cmp(2, 8, "R7");

      // R8 same ratio: 512 -> 512 keeps lock and phase
      mode_sel = 3'd3;
      repeat (2) @(negedge clk);
      check(lock_o == 1'b1, "R8", int'(lock_o), 1, "lock kept on same-ratio mode change");
      run_cmp(0, 1, "R8");

      // R8 ratio change: 512 -> 640
      mode_sel = 3'd2;
      @(negedge clk);
      check(lock_o == 1'b0, "R8", int'(lock_o), 0, "lock cleared by ratio change");
      good_m = 0;
      run_cmp(0, 8, "R8");

      // R9 divider rewrite
      good_m = 0;
      lag_r = 0;
      expect_cmp(0, "R9");
      div_load = 1'b1;
      @(negedge clk);
      div_load = 1'b0;
      check(lock_o == 1'b0, "R9", int'(lock_o), 0, "lock cleared by divider rewrite");
      n = 1;
      while (!ref_tick_o) begin @(negedge clk); n++; end
      check(n == 640, "R9", n, 640, "cycles from rewrite to strobe");
      drain();
      run_cmp(0, 7, "R7");

      // R4 muted pump across several comparisons
      pump_off = 1'b1;
      n = 0;
      repeat (1500) begin
         @(negedge clk);
         if (pump_up || pump_dn) n++;
      end
      pump_off = 1'b0;
      check(n == 0, "R4", n, 0, "pump activity while muted");
      run_cmp(0, 2, "R4");

      report();
   end

endmodule